// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation analog-to-digital converter with six multiplexed inputs. When idle it takes a start pulse together with a 3-bit channel number. It latches the channel onto the multiplexer select, holds the sample switch closed for a fixed sampling window and then searches for the code from the most significant bit down to the least. During the search it drives a trial code to an external DAC and reads back one comparator bit.

After the search it copies the code into a result register and raises a done flag. That flag serves as the interrupt request. The flag stays up until software acknowledges it or starts the next conversion.

Every conversion takes 26 conversion-clock periods. The first 6 are sampling, the next 16 are eight bit trials of two periods each, and the last 4 are for result transfer. A rate-select input decides whether each conversion period is one or two system-clock cycles. The comparator, DAC and sample capacitor are outside the block.

Top module: `sar_seq_top`

## Requirements
- R1: After synchronous reset: busy_o=0, sample_o=0, done_o=0, result_o=00h, dac_code_o=00h, mux_sel_o=0.
- R2: A start is accepted only when the block is idle and chan_sel_i is 0 to 5. At the accepting edge mux_sel_o takes chan_sel_i and busy_o rises. A start with channel 6 or 7 leaves the block idle.
- R3: busy_o stays high for exactly 26 conversion periods. A conversion period is one system cycle when clk_half_i=0 and two cycles when clk_half_i=1. clk_half_i is sampled only at the accepting edge, so 52 cycles is 3.25 us at 16 MHz.
- R4: sample_o is high during the first 6 conversion periods of a conversion and low at all other times.
- R5: dac_code_o is 00h while sampling. Periods 6+2i and 7+2i (0-based) form the trial slot for bit 7-i. The trial bit is set at the end of the first period of its slot, so during period 7 dac_code_o reads 80h.
- R6: cmp_i=1 means the input is at or above dac_code_o. The trial bit is kept when cmp_i=1 at the end of its slot and cleared otherwise. With an ideal comparator, result_o equals the input code for every code 00h to FFh.
- R7: result_o and done_o=1 are loaded on the edge where busy_o falls. result_o then holds until the next conversion completes.
- R8: done_o is cleared by ack_i while idle and by an accepted start. ack_i has no effect on result_o.
- R9: A start while busy is ignored. Changes to chan_sel_i during a conversion leave mux_sel_o, the duration and the result of that conversion unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| chan_sel_i | input | 3 | Channel to convert (0..5) |
| clk_half_i | input | 1 | 1 = conversion clock is system clock divided by 2 |
| ack_i | input | 1 | Clears the done flag |
| cmp_i | input | 1 | Comparator: input is at or above the DAC level |
| mux_sel_o | output | 3 | Analog multiplexer select |
| sample_o | output | 1 | Sample switch closed |
| dac_code_o | output | 8 | Trial code for the DAC |
| result_o | output | 8 | Last conversion result |
| done_o | output | 1 | Result ready / interrupt request |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench runs all 256 input codes at both clock rates and rotates the channel on each run. It counts busy and sampling cycles and probes the trial code in the first period where a trial bit is shown. An off-by-one in any phase counter changes the busy or sample cycle count. A missing divider hold gives 26 instead of 52 cycles. A wrong compare polarity or bit order corrupts the codes near 00h, 7Fh/80h and FFh.

Other runs fire a second start and change the channel in the middle of a conversion, and the other inputs are loaded with different codes. A block that re-latches the channel therefore returns a wrong result or a wrong duration. Separate runs cover a rejected out-of-range channel, acknowledge versus restart clearing of the flag, and a result that must survive the acknowledge.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Conversion phases of the sequencer
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SAMP  = 2'd1,
    PH_TRIAL = 2'd2,
    PH_XFER  = 2'd3
  } phase_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_tick_gen.sv
// Conversion-clock enable: every cycle, or every second cycle.
// The rate select is captured when a conversion is accepted.
module sar_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic half_i,
  output logic tick_o
);
  logic half_q;
  logic div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      div_q  <= 1'b0;
    end else if (clear_i) begin
      half_q <= half_i;
      div_q  <= 1'b0;
    end else begin
      div_q  <= ~div_q;
    end
  end

  assign tick_o = half_q ? div_q : 1'b1;
endmodule

// File: rtl/sar_ctrl.sv
// Phase sequencing: sampling, bit trials, result transfer.
// BIT_CYC must be at least 2 (set and evaluate in separate periods).
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES        = 8,
  parameter int NUM_CH     = 6,
  parameter int CH_W       = 3,
  parameter int SAMPLE_CYC = 6,
  parameter int BIT_CYC    = 2,
  parameter int XFER_CYC   = 4,
  localparam int BIT_W     = $clog2(RES),
  localparam int CNT_W     = $clog2(max3(SAMPLE_CYC, BIT_CYC, XFER_CYC) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic             accept_o,
  output logic [CH_W-1:0]  mux_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             set_o,
  output logic             eval_o,
  output logic             load_o,
  output logic [BIT_W-1:0] bit_o
);
  localparam logic [CH_W-1:0]  LAST_CH   = CH_W'(NUM_CH - 1);
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(BIT_CYC - 1);
  localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(XFER_CYC - 1);
  localparam logic [BIT_W-1:0] MSB_IDX   = BIT_W'(RES - 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic [CH_W-1:0]  mux_q;
  logic             sample_q;

  assign accept_o = (phase_q == PH_IDLE) && start_i && (chan_i <= LAST_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      mux_q    <= '0;
      sample_q <= 1'b0;
    end else if (accept_o) begin
      phase_q  <= PH_SAMP;
      cnt_q    <= '0;
      bit_q    <= MSB_IDX;
      mux_q    <= chan_i;
      sample_q <= 1'b1;
    end else if (tick_i) begin
      unique case (phase_q)
        PH_SAMP: begin
          if (cnt_q == SAMP_LAST) begin
            phase_q  <= PH_TRIAL;
            cnt_q    <= '0;
            sample_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_TRIAL: begin
          if (cnt_q == BIT_LAST) begin
            cnt_q <= '0;
            if (bit_q == '0) phase_q <= PH_XFER;
            else             bit_q   <= bit_q - 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_XFER: begin
          if (cnt_q == XFER_LAST) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign set_o    = tick_i && (phase_q == PH_TRIAL) && (cnt_q == '0);
  assign eval_o   = tick_i && (phase_q == PH_TRIAL) && (cnt_q == BIT_LAST);
  assign load_o   = tick_i && (phase_q == PH_XFER)  && (cnt_q == XFER_LAST);
  assign bit_o    = bit_q;
  assign mux_o    = mux_q;
  assign sample_o = sample_q;
  assign busy_o   = (phase_q != PH_IDLE);
endmodule

// File: rtl/sar_reg.sv
// Approximation register, result register and done flag.
module sar_reg #(
  parameter int RES    = 8,
  localparam int BIT_W = $clog2(RES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             set_i,
  input  logic             eval_i,
  input  logic             load_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             cmp_i,
  input  logic             ack_i,
  output logic [RES-1:0]   dac_o,
  output logic [RES-1:0]   result_o,
  output logic             done_o
);
  logic [RES-1:0] sar_q;
  logic [RES-1:0] res_q;
  logic           done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sar_q <= '0;
    end else if (clear_i) begin
      sar_q <= '0;
    end else if (set_i) begin
      sar_q[bit_i] <= 1'b1;
    end else if (eval_i) begin
      sar_q[bit_i] <= cmp_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      res_q  <= sar_q;
      done_q <= 1'b1;
    end else if (clear_i || ack_i) begin
      done_q <= 1'b0;
    end
  end

  assign dac_o    = sar_q;
  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES        = 8,
  parameter int NUM_CH     = 6,
  parameter int CH_W       = 3,
  parameter int SAMPLE_CYC = 6,
  parameter int BIT_CYC    = 2,
  parameter int XFER_CYC   = 4,
  localparam int BIT_W     = $clog2(RES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [CH_W-1:0] chan_sel_i,
  input  logic            clk_half_i,
  input  logic            ack_i,
  input  logic            cmp_i,
  output logic [CH_W-1:0] mux_sel_o,
  output logic            sample_o,
  output logic [RES-1:0]  dac_code_o,
  output logic [RES-1:0]  result_o,
  output logic            done_o,
  output logic            busy_o
);
  logic             tick;
  logic             accept;
  logic             set_s;
  logic             eval_s;
  logic             load_s;
  logic [BIT_W-1:0] bit_s;

  sar_tick_gen u_tick (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept),
    .half_i  (clk_half_i),
    .tick_o  (tick)
  );

  sar_ctrl #(
    .RES        (RES),
    .NUM_CH     (NUM_CH),
    .CH_W       (CH_W),
    .SAMPLE_CYC (SAMPLE_CYC),
    .BIT_CYC    (BIT_CYC),
    .XFER_CYC   (XFER_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .start_i  (start_i),
    .chan_i   (chan_sel_i),
    .accept_o (accept),
    .mux_o    (mux_sel_o),
    .sample_o (sample_o),
    .busy_o   (busy_o),
    .set_o    (set_s),
    .eval_o   (eval_s),
    .load_o   (load_s),
    .bit_o    (bit_s)
  );

  sar_reg #(
    .RES (RES)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (accept),
    .set_i    (set_s),
    .eval_i   (eval_s),
    .load_i   (load_s),
    .bit_i    (bit_s),
    .cmp_i    (cmp_i),
    .ack_i    (ack_i),
    .dac_o    (dac_code_o),
    .result_o (result_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES    = 8,
  parameter int NUM_CH = 6,
  parameter int CH_W   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            ack_i,
  input logic [CH_W-1:0] mux_sel_o,
  input logic            sample_o,
  input logic [RES-1:0]  result_o,
  input logic            done_o,
  input logic            busy_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  // R2
  mux_range_chk: assert property (@(posedge clk) disable iff (rst)
    mux_sel_o <= LAST_CH);

  // R4
  sample_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> busy_o);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> $stable(result_o));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !busy_o) |=> !done_o);

  // R9
  mux_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));
endmodule

bind sar_seq_top sar_seq_chk #(
  .RES    (RES),
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack_i     (ack_i),
  .mux_sel_o (mux_sel_o),
  .sample_o  (sample_o),
  .result_o  (result_o),
  .done_o    (done_o),
  .busy_o    (busy_o)
);

// File: tb/tb_sar_seq_top.sv
`timescale 1ns/1ps
module tb_sar_seq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] chan_sel_i = 3'd0;
  logic       clk_half_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       cmp_i;
  logic [2:0] mux_sel_o;
  logic       sample_o;
  logic [7:0] dac_code_o;
  logic [7:0] result_o;
  logic       done_o;
  logic       busy_o;

  logic [7:0] vin [6];
  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  // ideal comparator: 1 when the selected input is at or above the DAC level
  assign cmp_i = (vin[mux_sel_o] >= dac_code_o);

  sar_seq_top dut (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_sel_i(chan_sel_i),
    .clk_half_i(clk_half_i), .ack_i(ack_i), .cmp_i(cmp_i),
    .mux_sel_o(mux_sel_o), .sample_o(sample_o), .dac_code_o(dac_code_o),
    .result_o(result_o), .done_o(done_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // One conversion; intf fires a second start with another channel mid-way
  task automatic run_conv(input int ch, input int code, input bit half, input bit intf);
    int d, n, samp, oth;
    d = half ? 2 : 1;
    oth = (ch + 1) % 6;
    for (int k = 0; k < 6; k++) vin[k] = 8'(255 - code);
    vin[ch] = 8'(code);
    @(negedge clk);
    start_i = 1'b1; chan_sel_i = 3'(ch); clk_half_i = half;
    @(negedge clk);
    start_i = 1'b0; clk_half_i = ~half;
    chk(mux_sel_o == 3'(ch), "R2 mux latch", mux_sel_o, ch);
    chk(done_o == 1'b0, "R8 start clears done", done_o, 0);
    n = 0; samp = 0;
    while (busy_o && n < 200) begin
      if (sample_o) samp++;
      if (n == 0) chk(dac_code_o == 8'h00, "R5 dac idle in sampling", dac_code_o, 0);
      if (n == 7 * d) chk(dac_code_o == 8'h80, "R5 MSB trial", dac_code_o, 128);
      if (intf && n == 10) begin start_i = 1'b1; chan_sel_i = 3'(oth); end
      else begin start_i = 1'b0; chan_sel_i = 3'(oth); end
      n++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(n == 26 * d, intf ? "R9 duration with restart" : "R3 busy length", n, 26 * d);
    chk(samp == 6 * d, "R4 sample length", samp, 6 * d);
    chk(result_o == 8'(code), intf ? "R9 result unchanged" : "R6 result", result_o, code);
    chk(done_o == 1'b1, "R7 done set", done_o, 1);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 6; k++) vin[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(sample_o == 0, "R1 sample", sample_o, 0);
    chk(done_o == 0, "R1 done", done_o, 0);
    chk(result_o == 0, "R1 result", result_o, 0);
    chk(dac_code_o == 0, "R1 dac", dac_code_o, 0);
    chk(mux_sel_o == 0, "R1 mux", mux_sel_o, 0);

    // Exhaustive sweep over codes at both rates (R3 R4 R5 R6 R7)
    for (int h = 0; h < 2; h++)
      for (int c = 0; c < 256; c++)
        run_conv(c % 6, c, h[0], 1'b0);

    // R9 restart and channel change during conversion
    run_conv(2, 8'h5A, 1'b0, 1'b1);
    run_conv(5, 8'hA5, 1'b1, 1'b1);
    run_conv(0, 8'h80, 1'b1, 1'b1);

    // R8 acknowledge clears done, result kept
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
    chk(done_o == 0, "R8 ack clears done", done_o, 0);
    chk(result_o == 8'h80, "R8 ack keeps result", result_o, 128);

    // R2 out-of-range channels are rejected
    for (int ch = 6; ch < 8; ch++) begin
      @(negedge clk); start_i = 1'b1; chan_sel_i = 3'(ch);
      @(negedge clk); start_i = 1'b0;
      chk(busy_o == 0, "R2 bad channel busy", busy_o, 0);
      chk(mux_sel_o == 3'd0, "R2 bad channel mux", mux_sel_o, 0);
      repeat (3) @(negedge clk);
      chk(result_o == 8'h80 && done_o == 0, "R2 bad channel no conversion", result_o, 128);
    end

    // Boundary codes on the last channel, slow rate
    run_conv(5, 8'hFF, 1'b1, 1'b0);
    run_conv(5, 8'h00, 1'b1, 1'b0);
    run_conv(3, 8'h7F, 1'b0, 1'b0);

    finish_run();
  end
endmodule